// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block holds the power-saving control register of a small controller and turns its two mode bits into clock enables. Software sets the idle bit to halt the processor clock while timers, the serial port and interrupt logic keep running. It sets the power-down bit to halt every clock in the device. The block drives enable signals only. Gating cells and the interrupt controller sit outside it.

An enabled, pending interrupt leaves idle by clearing the idle bit. The processor then resumes with all its state intact. Power-down ignores interrupts, and only the hardware reset clears it. The read port always shows the live bits, so after a wake-up software reads the idle bit as zero. A new mode takes effect one edge after the write edge, so the instruction that made the write completes first.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A synchronous active-low reset clears both mode bits, reports mode run (`mode` = 2'b00), and drives both clock enables to 1.
- R2: A write accepted with only bit 0 (idle) set shows bit 0 on `rd_data` after the write edge. One edge later, `mode` becomes idle (2'b01), `cpu_clk_en` goes to 0 and `periph_clk_en` stays at 1.
- R3: A write accepted with bit 1 (power-down) set shows bit 1 on `rd_data` after the write edge. One edge later, `mode` becomes power-down (2'b10) and both enables go to 0.
- R4: When both bits are written as 1 in one write, `rd_data` shows both bits and power-down takes precedence: mode 2'b10 with both enables at 0.
- R5: In idle with power-down clear, a high `irq_pending` clears bit 0 at the next edge. Mode run and `cpu_clk_en` = 1 return one edge after that.
- R6: While the power-down bit is set, `irq_pending` has no effect: the register and the mode stay unchanged.
- R7: A write is accepted only while `mode` reports run. Writes in idle or power-down leave the register unchanged.
- R8: The hardware reset exits both idle and power-down, returning to the state of R1.
- R9: Register bits other than 0 and 1 always read as 0, and writing them has no effect.
- R10: `cpu_clk_en` is 1 exactly when `mode` is run. `periph_clk_en` is 0 exactly when `mode` is power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe for the power-control register |
| wr_data | input | REG_W | Write data (bit 0 idle, bit 1 power-down) |
| irq_pending | input | 1 | An enabled interrupt is pending |
| rd_data | output | REG_W | Live register value |
| mode | output | 2 | Current mode: 00 run, 01 idle, 10 power-down |
| cpu_clk_en | output | 1 | Clock enable for the processor core |
| periph_clk_en | output | 1 | Clock enable for timers, serial port and interrupt logic |

## Verification
The bench builds the block with its default values: an 8-bit register, idle in bit 0 and power-down in bit 1. With the full byte width, the bench writes random values to the six reserved bits and checks that they stay invisible on the read port. The fixed bit positions let the bench write both mode bits at once to exercise the precedence rule. They also let it raise interrupts at the exact edges where idle ends or power-down holds.

// File: rtl/pwr_pkg.sv
// Package pwr_pkg
// Purpose: shared mode encoding for the power-mode controller.
// Assumes: a two-bit mode code is enough for run, idle and power-down.
package pwr_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_IDLE  = 2'b01,
        MODE_PDOWN = 2'b10
    } pwr_mode_t;
endpackage

// File: rtl/pwr_ctl_reg.sv
// Module pwr_ctl_reg
// Purpose: holds the idle and power-down bits, applies accepted writes
//          and clears the idle bit when an interrupt wakes the core.
// Assumes: wr_accept is already qualified by the current mode; an
//          accepted write has priority over an interrupt wake-up.
module pwr_ctl_reg #(
    parameter int REG_W    = 8,
    parameter int IDLE_BIT = 0,
    parameter int PD_BIT   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_accept,
    input  logic [REG_W-1:0] wr_data,
    input  logic             irq_pending,
    output logic             idle_q,
    output logic             pd_q
);
    // Interrupts may only end idle, never power-down.
    logic wake;
    assign wake = irq_pending && idle_q && !pd_q;

    // Update the mode bits from writes, wake-up and reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 1'b0;
            pd_q   <= 1'b0;
        end else if (wr_accept) begin
            idle_q <= wr_data[IDLE_BIT];
            pd_q   <= wr_data[PD_BIT];
        end else if (wake) begin
            idle_q <= 1'b0;
        end
    end

    // R5: a pending interrupt in idle clears the idle bit
    a_r5_irq_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_accept && irq_pending && idle_q && !pd_q) |=> !idle_q);

    // R6: power-down survives anything but a write or reset
    a_r6_pd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_q && !wr_accept) |=> (pd_q && $stable(idle_q)));
endmodule

// File: rtl/pwr_mode_fsm.sv
// Module pwr_mode_fsm
// Purpose: registers the reported mode from the register bits and
//          qualifies register writes with the current mode.
// Assumes: power-down outranks idle when both bits are set.
module pwr_mode_fsm
    import pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      idle_q,
    input  logic      pd_q,
    output pwr_mode_t mode_q,
    output logic      wr_accept
);
    pwr_mode_t mode_d;

    // Decode the mode the bits ask for, power-down first.
    always_comb begin
        if (pd_q)        mode_d = MODE_PDOWN;
        else if (idle_q) mode_d = MODE_IDLE;
        else             mode_d = MODE_RUN;
    end

    // Hold the reported mode one edge behind the register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    // Writes come only from a running core.
    assign wr_accept = wr_en && (mode_q == MODE_RUN);

    // R4: power-down bit wins over idle bit
    a_r4_pd_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pd_q |=> (mode_q == MODE_PDOWN));

    // R2: idle bit alone leads to idle mode
    a_r2_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && !pd_q) |=> (mode_q == MODE_IDLE));
endmodule

// File: rtl/pwr_clken_gen.sv
// Module pwr_clken_gen
// Purpose: registers the processor and peripheral clock enables from
//          the mode bits, in step with the reported mode.
// Assumes: enables are active high and reset to running.
module pwr_clken_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_q,
    input  logic pd_q,
    output logic cpu_clk_en,
    output logic periph_clk_en
);
    // Drop the processor clock in either mode, peripherals only in power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_clk_en    <= 1'b1;
            periph_clk_en <= 1'b1;
        end else begin
            cpu_clk_en    <= !(idle_q || pd_q);
            periph_clk_en <= !pd_q;
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module pwr_mode_ctrl
// Purpose: top of the power-mode controller; joins the register,
//          the mode tracker and the enable generator.
// Assumes: the register is REG_W bits wide, mode bits at IDLE_BIT and
//          PD_BIT, all other bits reserved and read as zero.
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int IDLE_BIT = 0,
    parameter int PD_BIT   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             irq_pending,
    output logic [REG_W-1:0] rd_data,
    output logic [1:0]       mode,
    output logic             cpu_clk_en,
    output logic             periph_clk_en
);
    logic      idle_q;
    logic      pd_q;
    logic      wr_accept;
    pwr_mode_t mode_q;

    pwr_ctl_reg #(.REG_W(REG_W), .IDLE_BIT(IDLE_BIT), .PD_BIT(PD_BIT)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept), .wr_data(wr_data),
        .irq_pending(irq_pending), .idle_q(idle_q), .pd_q(pd_q)
    );

    pwr_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idle_q(idle_q),
        .pd_q(pd_q), .mode_q(mode_q), .wr_accept(wr_accept)
    );

    pwr_clken_gen u_clken (
        .clk(clk), .rst_n(rst_n), .idle_q(idle_q), .pd_q(pd_q),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en)
    );

    // Place live mode bits, reserved bits read as zero.
    for (genvar i = 0; i < REG_W; i++) begin : g_rd
        if (i == IDLE_BIT)    begin : g_idle assign rd_data[i] = idle_q; end
        else if (i == PD_BIT) begin : g_pd   assign rd_data[i] = pd_q;   end
        else                  begin : g_rsv  assign rd_data[i] = 1'b0;   end
    end

    assign mode = mode_q;

    // R1: first cycle out of reset shows the run state
    a_r1_reset_state: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |->
        (mode == MODE_RUN && rd_data == '0 && cpu_clk_en && periph_clk_en));

    // R10: enables agree with the reported mode
    a_r10_run_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN) |-> (cpu_clk_en && periph_clk_en));
    a_r10_idle_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE) |-> (!cpu_clk_en && periph_clk_en));
    a_r10_pd_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PDOWN) |-> (!cpu_clk_en && !periph_clk_en));

    // R7: writes outside run mode leave the register alone
    a_r7_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode != MODE_RUN && !irq_pending) |=> $stable(rd_data));
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         irq_pending = 1'b0;
    logic [W-1:0] rd_data;
    logic [1:0]   mode;
    logic         cpu_clk_en;
    logic         periph_clk_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference state held by the bench
    bit       m_idle = 1'b0;
    bit       m_pd = 1'b0;
    bit [1:0] m_mode = 2'b00;

    pwr_mode_ctrl #(.REG_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_pending(irq_pending), .rd_data(rd_data), .mode(mode),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en)
    );

    always #2ns clk = ~clk;

    function automatic bit [1:0] mode_of(bit idle, bit pd);
        if (pd)   return 2'b10;
        if (idle) return 2'b01;
        return 2'b00;
    endfunction

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(bit w, logic [W-1:0] d, bit irq, bit rst, string req);
        bit n_idle, n_pd;
        bit [1:0] n_mode;
        wr_en = w; wr_data = d; irq_pending = irq; rst_n = !rst;
        n_idle = m_idle; n_pd = m_pd;
        if (rst) begin
            n_idle = 0; n_pd = 0; n_mode = 2'b00;
        end else begin
            n_mode = mode_of(m_idle, m_pd);
            if (w && m_mode == 2'b00) begin
                n_idle = d[0]; n_pd = d[1];
            end else if (irq && m_idle && !m_pd) begin
                n_idle = 0;
            end
        end
        @(posedge clk);
        #2ns;
        m_idle = n_idle; m_pd = n_pd; m_mode = n_mode;
        chk(req, "rd_data", rd_data, {{(W-2){1'b0}}, m_pd, m_idle});
        chk(req, "mode", {{(W-2){1'b0}}, mode}, {{(W-2){1'b0}}, m_mode});
        chk(req, "cpu_clk_en", {{(W-1){1'b0}}, cpu_clk_en},
            {{(W-1){1'b0}}, (m_mode == 2'b00)});
        chk(req, "periph_clk_en", {{(W-1){1'b0}}, periph_clk_en},
            {{(W-1){1'b0}}, (m_mode != 2'b10)});
    endtask

    task automatic idle_run(int n, string req);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, req);
    endtask

    initial begin
        #2ns;
        // R1: reset state
        step(0, '0, 0, 1, "R1");
        step(0, '0, 0, 1, "R1");
        idle_run(2, "R1");
        // R2: enter idle, then R7 write ignored while idle
        step(1, 8'h01, 0, 0, "R2");
        idle_run(3, "R2");
        step(1, 8'h00, 0, 0, "R7");
        idle_run(2, "R7");
        // R5: interrupt wakes idle
        step(0, '0, 1, 0, "R5");
        idle_run(3, "R5");
        // R9: reserved bits stay zero
        step(1, 8'hFC, 0, 0, "R9");
        idle_run(2, "R9");
        // R3: power-down, R6 interrupts ignored, R7 write ignored
        step(1, 8'h02, 0, 0, "R3");
        idle_run(2, "R3");
        for (int i = 0; i < 4; i++) step(0, '0, 1, 0, "R6");
        step(1, 8'h00, 0, 0, "R7");
        idle_run(2, "R7");
        // R8: reset leaves power-down
        step(0, '0, 0, 1, "R8");
        idle_run(2, "R8");
        // R4: both bits set, power-down wins, interrupt cannot clear idle
        step(1, 8'h03, 0, 0, "R4");
        idle_run(2, "R4");
        step(0, '0, 1, 0, "R4");
        idle_run(2, "R4");
        step(0, '0, 0, 1, "R8");
        // R8: reset leaves idle
        step(1, 8'hA5, 0, 0, "R8");
        idle_run(2, "R8");
        step(0, '0, 0, 1, "R8");
        idle_run(2, "R10");
        // Random phase
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 3000; i++) begin
            bit w, irq, rst;
            logic [W-1:0] d;
            string req;
            w   = ($urandom % 4) == 0;
            irq = ($urandom % 6) == 0;
            rst = ($urandom % 60) == 0;
            d   = W'($urandom);
            if (rst)        req = "R8";
            else if (m_pd)  req = "R6";
            else if (m_idle) req = "R5";
            else            req = "R10";
            step(w, d, irq, rst, req);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800us;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule